// File: doc/BRIEF.md
# Linear-to-Physical Address Translator with Translation Cache

This block converts 32-bit linear addresses into physical addresses for a core's memory pipeline. With paging switched off the address passes through untouched. With paging on, the address is cut into a directory index (bits 31:22), a table index (bits 21:12) and a byte offset (bits 11:0). A fully associative cache of recent translations is looked up first. On a miss, the block walks a two-level table in memory: first the directory, then one page table. Each table holds 1024 entries of 32 bits.

A requester offers one address at a time on a valid/ready pair. The block answers with a one-cycle response pulse. The pulse carries the physical address, a page-fault flag, and the cache-disable attribute of the page. The directory base lives in a register inside the block. Writing that register empties the translation cache.

Top module: `linear_xlate_unit`

## Requirements
- R1: When `pg_enable` is 0 at acceptance, the response arrives one cycle later with `rsp_phys` equal to the linear address and `rsp_fault` = 0. No memory read is made.
- R2: The low 12 bits of any non-faulting translated address equal the low 12 bits of the linear address. The directory entry is read at {base[31:12], lin[31:22], 2'b00}. The table entry is read at {dir_entry[31:12], lin[21:12], 2'b00}.
- R3: A cache miss with both entries present makes exactly two memory reads, directory first. It then responds with `rsp_phys` = {table_entry[31:12], lin[11:0]}. The read address is held steady until its data returns.
- R4: A lookup that hits the translation cache responds one cycle after acceptance and makes no memory read.
- R5: A directory entry with bit 0 (present) clear ends the walk after one read with `rsp_fault` = 1. The failed page is not cached, so a repeat request walks again.
- R6: A table entry with bit 0 clear gives `rsp_fault` = 1 after two reads. The page is not cached.
- R7: The cache holds 32 translations and replaces them in round-robin order. After 33 distinct fills, the first-filled page misses and the second-filled page still hits.
- R8: Writing the directory base empties the cache, even if the value is unchanged. Later walks use the new base.
- R9: `rsp_cache_off` equals bit 4 of the table entry on a miss. It equals the cached copy of that bit on a hit. It is 0 when paging is off.
- R10: `req_ready` is low while a walk is in progress. `rsp_valid` is a single-cycle pulse.
- R11: After reset, `req_ready` is 1, `rsp_valid` and `mem_req` are 0, and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Linear address offered |
| req_ready | output | 1 | Block can accept an address |
| req_lin | input | 32 | Linear address |
| pg_enable | input | 1 | Paging on (1) or bypass (0), sampled at acceptance |
| base_wr | input | 1 | Write strobe for the directory base register |
| base_wdata | input | 32 | New directory base (bits 31:12 used) |
| mem_req | output | 1 | Table entry read request |
| mem_addr | output | 32 | Byte address of the entry to read |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Response pulse |
| rsp_phys | output | 32 | Physical address |
| rsp_fault | output | 1 | Page fault (entry not present) |
| rsp_cache_off | output | 1 | Page marked not cacheable |

## Verification
Bypass requests with an arbitrary address show that translation is really skipped. They also show that no memory read happens. A first touch of a page and a second touch of the same page at another offset separate the walk path from the hit path. The test looks at the read count, the latency and the first read address. Faulting pages at each table level, each requested twice, show whether a failed walk leaks into the cache. A run of 33 distinct pages, followed by probes of the second and then the first page, pins down the replacement order. Base writes, with the same value and with a new one, show the flush and show that the new base is used.

// File: rtl/lxu_pkg.sv
// Shared widths and entry layout for the linear address translator.
// Assumes 32-bit addresses and 4 KB pages split 10/10/12.
package lxu_pkg;
    localparam int LIN_W   = 32;
    localparam int OFF_W   = 12;
    localparam int IDX_W   = 10;
    localparam int PN_W    = LIN_W - OFF_W;
    localparam int PRESENT_BIT = 0;
    localparam int NOCACHE_BIT = 4;

    typedef struct packed {
        logic [PN_W-1:0] frame;
        logic            nocache;
    } xlat_t;
endpackage

// File: rtl/lxu_tlb.sv
// Fully associative cache of page translations with round-robin refill.
// Assumes a fill never targets a page that is already present (fills only follow misses).
module lxu_tlb
    import lxu_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic [PN_W-1:0] look_pn,
    output logic            hit,
    output xlat_t           hit_xlat,
    input  logic            fill,
    input  logic [PN_W-1:0] fill_pn,
    input  xlat_t           fill_xlat
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] vld;
    logic [PN_W-1:0]  tag [DEPTH];
    xlat_t            dat [DEPTH];
    logic [DEPTH-1:0] match;
    logic [PTR_W-1:0] ptr;

    // per-entry tag comparators
    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_cmp
            assign match[g] = vld[g] && (tag[g] == look_pn);
        end
    endgenerate

    // merge the data of the matching entry
    always_comb begin
        hit      = |match;
        hit_xlat = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) hit_xlat = hit_xlat | dat[i];
        end
    end

    // valid bits and replacement pointer; flush wins over fill
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            vld <= '0;
            ptr <= '0;
        end else if (fill) begin
            vld[ptr] <= 1'b1;
            ptr      <= (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
        end
    end

    // tag and data storage, written at the pointer
    always_ff @(posedge clk) begin
        if (fill && !flush) begin
            tag[ptr] <= fill_pn;
            dat[ptr] <= fill_xlat;
        end
    end
endmodule

// File: rtl/lxu_walker.sv
// Two-step table walk: directory entry, then page table entry.
// Assumes the memory holds mem_rdata valid for the cycle mem_rvalid is high.
// done pulses with the result in the cycle the final entry arrives.
module lxu_walker
    import lxu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PN_W-1:0]  start_pn,
    input  logic [PN_W-1:0]  base_frame,
    output logic             busy,
    output logic             mem_req,
    output logic [LIN_W-1:0] mem_addr,
    input  logic             mem_rvalid,
    input  logic [LIN_W-1:0] mem_rdata,
    output logic             done,
    output logic             fault,
    output xlat_t            result
);
    typedef enum logic [1:0] {W_IDLE, W_DIR, W_TBL} wstate_t;

    wstate_t         st;
    logic [PN_W-1:0] pn_q;
    logic [PN_W-1:0] base_q;
    logic [PN_W-1:0] tbl_q;
    logic            present;

    assign present = mem_rdata[PRESENT_BIT];
    assign busy    = (st != W_IDLE);
    assign mem_req = busy;

    // entry address for the current level
    always_comb begin
        if (st == W_TBL) mem_addr = {tbl_q, pn_q[IDX_W-1:0], 2'b00};
        else             mem_addr = {base_q, pn_q[PN_W-1:IDX_W], 2'b00};
    end

    // completion and its result
    always_comb begin
        done   = mem_rvalid && ((st == W_TBL) || (st == W_DIR && !present));
        fault  = !present;
        result = '{frame: mem_rdata[LIN_W-1:OFF_W], nocache: mem_rdata[NOCACHE_BIT]};
    end

    // walk sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= W_IDLE;
        end else begin
            case (st)
                W_IDLE: if (start) st <= W_DIR;
                W_DIR:  if (mem_rvalid) st <= present ? W_TBL : W_IDLE;
                W_TBL:  if (mem_rvalid) st <= W_IDLE;
                default: st <= W_IDLE;
            endcase
        end
    end

    // walk operands captured at start and after the directory read
    always_ff @(posedge clk) begin
        if (st == W_IDLE && start) begin
            pn_q   <= start_pn;
            base_q <= base_frame;
        end
        if (st == W_DIR && mem_rvalid) tbl_q <= mem_rdata[LIN_W-1:OFF_W];
    end
endmodule

// File: rtl/linear_xlate_unit.sv
// Top: accepts linear addresses, bypasses or translates, owns the directory base.
// Assumes one request in flight; the base should be written only when idle.
module linear_xlate_unit
    import lxu_pkg::*;
#(
    parameter int TLB_DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [LIN_W-1:0] req_lin,
    input  logic             pg_enable,
    input  logic             base_wr,
    input  logic [LIN_W-1:0] base_wdata,
    output logic             mem_req,
    output logic [LIN_W-1:0] mem_addr,
    input  logic             mem_rvalid,
    input  logic [LIN_W-1:0] mem_rdata,
    output logic             rsp_valid,
    output logic [LIN_W-1:0] rsp_phys,
    output logic             rsp_fault,
    output logic             rsp_cache_off
);
    logic             accept;
    logic             hit;
    xlat_t            hit_x;
    logic             walk_busy, walk_done, walk_fault, walk_start;
    xlat_t            walk_x;
    logic [PN_W-1:0]  base_frame;
    logic [PN_W-1:0]  pn_q;
    logic [OFF_W-1:0] off_q;

    assign req_ready  = !walk_busy;
    assign accept     = req_valid && req_ready;
    assign walk_start = accept && pg_enable && !hit;

    // directory base register
    always_ff @(posedge clk) begin
        if (!rst_n)       base_frame <= '0;
        else if (base_wr) base_frame <= base_wdata[LIN_W-1:OFF_W];
    end

    lxu_tlb #(.DEPTH(TLB_DEPTH)) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (base_wr),
        .look_pn  (req_lin[LIN_W-1:OFF_W]),
        .hit      (hit),
        .hit_xlat (hit_x),
        .fill     (walk_done && !walk_fault),
        .fill_pn  (pn_q),
        .fill_xlat(walk_x)
    );

    lxu_walker u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (walk_start),
        .start_pn  (req_lin[LIN_W-1:OFF_W]),
        .base_frame(base_frame),
        .busy      (walk_busy),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_rvalid(mem_rvalid),
        .mem_rdata (mem_rdata),
        .done      (walk_done),
        .fault     (walk_fault),
        .result    (walk_x)
    );

    // hold page number and offset of the accepted request
    always_ff @(posedge clk) begin
        if (accept) begin
            pn_q  <= req_lin[LIN_W-1:OFF_W];
            off_q <= req_lin[OFF_W-1:0];
        end
    end

    // response register: bypass, hit or walk completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_phys      <= '0;
            rsp_fault     <= 1'b0;
            rsp_cache_off <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept && !pg_enable) begin
                rsp_valid     <= 1'b1;
                rsp_phys      <= req_lin;
                rsp_fault     <= 1'b0;
                rsp_cache_off <= 1'b0;
            end else if (accept && hit) begin
                rsp_valid     <= 1'b1;
                rsp_phys      <= {hit_x.frame, req_lin[OFF_W-1:0]};
                rsp_fault     <= 1'b0;
                rsp_cache_off <= hit_x.nocache;
            end else if (walk_done) begin
                rsp_valid     <= 1'b1;
                rsp_phys      <= walk_fault ? '0 : {walk_x.frame, off_q};
                rsp_fault     <= walk_fault;
                rsp_cache_off <= walk_fault ? 1'b0 : walk_x.nocache;
            end
        end
    end
endmodule

// File: rtl/linear_xlate_unit_chk.sv
// Property checker for linear_xlate_unit, attached by bind.
module linear_xlate_unit_chk
    import lxu_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [LIN_W-1:0] req_lin,
    input logic             pg_enable,
    input logic             mem_req,
    input logic [LIN_W-1:0] mem_addr,
    input logic             mem_rvalid,
    input logic             rsp_valid,
    input logic [LIN_W-1:0] rsp_phys,
    input logic             rsp_fault,
    input logic             rsp_cache_off
);
    logic [OFF_W-1:0] held_off;

    // offset of the last accepted request
    always_ff @(posedge clk) begin
        if (req_valid && req_ready) held_off <= req_lin[OFF_W-1:0];
    end

    assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !pg_enable) |=>
            (rsp_valid && !rsp_fault && rsp_phys == $past(req_lin)));

    assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_phys[OFF_W-1:0] == held_off));

    assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    assert_bypass_cacheable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !pg_enable) |=> !rsp_cache_off);

    assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

bind linear_xlate_unit linear_xlate_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_lin      (req_lin),
    .pg_enable    (pg_enable),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_rvalid   (mem_rvalid),
    .rsp_valid    (rsp_valid),
    .rsp_phys     (rsp_phys),
    .rsp_fault    (rsp_fault),
    .rsp_cache_off(rsp_cache_off)
);

// File: tb/linear_xlate_unit_tb.sv
module linear_xlate_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_lin = '0;
    logic        pg_enable = 1'b0;
    logic        base_wr = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        rsp_valid;
    logic [31:0] rsp_phys;
    logic        rsp_fault;
    logic        rsp_cache_off;

    int checks = 0;
    int errors = 0;
    int unsigned cyc = 0;
    int unsigned issue_cyc = 0;
    bit done_flag = 0;

    typedef struct {
        logic [31:0] phys;
        logic        fault;
        logic        cd;
        int          reads;
        int          lat;
        logic [31:0] first_addr;
        string       tag;
    } item_t;

    item_t       sb[$];
    logic [31:0] rd_log[$];
    logic [31:0] mem[int unsigned];

    always #2 clk = ~clk;

    linear_xlate_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_lin(req_lin), .pg_enable(pg_enable), .base_wr(base_wr),
        .base_wdata(base_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
        .rsp_phys(rsp_phys), .rsp_fault(rsp_fault), .rsp_cache_off(rsp_cache_off)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] rd_word(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // memory model: one-cycle read latency, one beat per request
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
        end else if (mem_req && !mem_rvalid) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= rd_word(mem_addr);
            rd_log.push_back(mem_addr);
        end else begin
            mem_rvalid <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pop expected items as responses appear
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                chk(0, "R10 unexpected response", 32'h1, 32'h0);
            end else begin
                item_t e;
                e = sb.pop_front();
                chk(rsp_fault == e.fault, {e.tag, " fault"}, 32'(rsp_fault), 32'(e.fault));
                if (!e.fault)
                    chk(rsp_phys == e.phys, {e.tag, " phys"}, rsp_phys, e.phys);
                chk(rsp_cache_off == e.cd, {e.tag, " R9 cache_off"}, 32'(rsp_cache_off), 32'(e.cd));
                chk(rd_log.size() == e.reads, {e.tag, " reads"}, 32'(rd_log.size()), 32'(e.reads));
                if (e.reads > 0 && rd_log.size() > 0)
                    chk(rd_log[0] == e.first_addr, {e.tag, " R2 first read addr"}, rd_log[0], e.first_addr);
                if (e.lat > 0)
                    chk(int'(cyc - issue_cyc) == e.lat, {e.tag, " latency"},
                        32'(cyc - issue_cyc), 32'(e.lat));
            end
        end
    end

    // driver: push expectation, perform handshake, wait for the answer
    task automatic issue(input logic [31:0] lin, input bit pg, input logic [31:0] ephys,
                         input bit efault, input bit ecd, input int ereads,
                         input int elat, input logic [31:0] efirst, input string tag);
        item_t e;
        e = '{phys: ephys, fault: efault, cd: ecd, reads: ereads, lat: elat,
              first_addr: efirst, tag: tag};
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        rd_log.delete();
        sb.push_back(e);
        req_valid = 1'b1;
        req_lin   = lin;
        pg_enable = pg;
        issue_cyc = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        if (ereads > 0)
            chk(!req_ready, {tag, " R10 ready low during walk"}, 32'(req_ready), 32'h0);
        while (sb.size() != 0) @(negedge clk);
    endtask

    task automatic write_base(input logic [31:0] v);
        @(negedge clk);
        base_wr = 1'b1;
        base_wdata = v;
        @(negedge clk);
        base_wr = 1'b0;
    endtask

    function automatic logic [31:0] dir_addr(input logic [31:0] base, input logic [31:0] lin);
        return {base[31:12], lin[31:22], 2'b00};
    endfunction

    function automatic logic [19:0] tbl_frame(input logic [31:0] base, input logic [31:0] lin);
        return base[31:12] + 20'd1 + 20'(lin[31:22]);
    endfunction

    // install directory entry for lin's table and optionally the page entry
    task automatic map_dir(input logic [31:0] base, input logic [31:0] lin);
        mem[dir_addr(base, lin)] = {tbl_frame(base, lin), 11'd0, 1'b1};
    endtask

    task automatic map_page(input logic [31:0] base, input logic [31:0] lin,
                            input logic [19:0] frame, input bit cd);
        map_dir(base, lin);
        mem[{tbl_frame(base, lin), lin[21:12], 2'b00}] = {frame, 7'd0, cd, 3'd0, 1'b1};
    endtask

    localparam logic [31:0] BASE1 = 32'h0010_0000;
    localparam logic [31:0] BASE2 = 32'h0020_0000;

    initial begin
        logic [31:0] la, lb;
        la = 32'h0040_3123;
        lb = 32'h0040_5ABC;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11 reset ready", 32'(req_ready), 32'h1);
        chk(rsp_valid == 1'b0, "R11 reset rsp_valid", 32'(rsp_valid), 32'h0);
        chk(mem_req == 1'b0, "R11 reset mem_req", 32'(mem_req), 32'h0);

        issue(32'hDEAD_BEEF, 0, 32'hDEAD_BEEF, 0, 0, 0, 1, 0, "R1 bypass");
        issue(32'h0000_0FFF, 0, 32'h0000_0FFF, 0, 0, 0, 1, 0, "R1 bypass low");

        write_base(BASE1);
        map_page(BASE1, la, 20'hABCDE, 0);
        map_page(BASE1, lb, 20'h12345, 1);
        issue(la, 1, {20'hABCDE, la[11:0]}, 0, 0, 2, 0, dir_addr(BASE1, la), "R3 miss walk");
        issue(la ^ 32'h0000_0777, 1, {20'hABCDE, la[11:0] ^ 12'h777}, 0, 0, 0, 1, 0, "R4 hit");
        issue(lb, 1, {20'h12345, lb[11:0]}, 0, 1, 2, 0, dir_addr(BASE1, lb), "R9 miss nocache");
        issue(lb, 1, {20'h12345, lb[11:0]}, 0, 1, 0, 1, 0, "R9 hit nocache");
        issue(32'h0040_3000, 0, 32'h0040_3000, 0, 0, 0, 1, 0, "R9 bypass cacheable");

        issue(32'h8000_0010, 1, 0, 1, 0, 1, 0, dir_addr(BASE1, 32'h8000_0010), "R5 dir absent");
        issue(32'h8000_0010, 1, 0, 1, 0, 1, 0, dir_addr(BASE1, 32'h8000_0010), "R5 not cached");
        issue(32'h0041_0040, 1, 0, 1, 0, 2, 0, dir_addr(BASE1, 32'h0041_0040), "R6 table absent");
        issue(32'h0041_0040, 1, 0, 1, 0, 2, 0, dir_addr(BASE1, 32'h0041_0040), "R6 not cached");

        write_base(BASE1);
        issue(la, 1, {20'hABCDE, la[11:0]}, 0, 0, 2, 0, dir_addr(BASE1, la), "R8 same base flush");
        write_base(BASE2);
        issue(la, 1, 0, 1, 0, 1, 0, dir_addr(BASE2, la), "R8 new base used");

        for (int i = 0; i < 33; i++) begin
            logic [31:0] l;
            l = 32'(i) << 12;
            map_page(BASE2, l, 20'h50000 + 20'(i), 0);
            issue(l, 1, {20'h50000 + 20'(i), 12'h000}, 0, 0, 2, 0, dir_addr(BASE2, l), "R7 fill");
        end
        issue(32'h0000_1004, 1, {20'h50001, 12'h004}, 0, 0, 0, 1, 0, "R7 second page kept");
        issue(32'h0000_0008, 1, {20'h50000, 12'h008}, 0, 0, 2, 0, dir_addr(BASE2, 0), "R7 first page evicted");

        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule